// File: doc/BRIEF.md
# Locked Read-Modify-Write Bus Sequencer

This block is a synchronous bus master that carries out one indivisible read-modify-write operation on a 32-bit external bus. An internal client raises a request with an address, an operand size, a write word and two beat counts. The sequencer then runs the read beats, holds a fixed number of quiet turnaround clocks, and runs the write beats. The bus lock stays asserted for the whole operation, so no other master can get in between the read and the write.

Every transfer takes at least two clocks. The first is the address clock, with the transfer-start strobe. The second is the data clock, which is stretched by wait states until the slave acknowledges. Read data comes back to the client as a one-clock valid pulse.

A separate strobe in the address clock of the last write beat tells an external arbiter that this locked operation ends there. The arbiter can then tell two back-to-back locked operations apart.

Top module: `rmw_bus_seq`

## Requirements
- R1: `req_ready_o` is high only when the sequencer is idle, and a request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. After reset, or after an asynchronous reset in the middle of a sequence, `req_ready_o` is 1 and `bus_lock_o`, `bus_busy_o`, `bus_start_o`, `bus_data_oe_o` and `bus_lock_last_o` are 0.
- R2: In the address clock of every beat, `bus_start_o` and `bus_busy_o` are 1, `bus_size_o` equals the request size, and `bus_addr_o` equals the request address plus 4 times the beat index within its phase. `bus_start_o` is 0 in the following clock.
- R3: A data clock repeats while `bus_ack_i` is low at the rising edge. During this wait, `bus_busy_o` stays 1, `bus_start_o` stays 0, and the write data and its output enable are held.
- R4: `rd_valid_o` pulses for one clock, one clock after the edge where a read data clock samples `bus_ack_i` high. In that clock `rd_data_o` holds the 32-bit bus word captured at that edge. Edges without an acknowledge produce no pulse.
- R5: A request field value k in `req_rd_beats_i` or `req_wr_beats_i` gives k+1 beats in that phase.
- R6: After the last read acknowledge there are exactly IDLE_CLKS turnaround clocks. In each of them `bus_busy_o`, `bus_start_o` and `bus_data_oe_o` are 0, while `bus_rnw_o` and `bus_lock_o` stay 1.
- R7: `bus_rnw_o` is 1 throughout read beats and 0 throughout write beats. `bus_data_oe_o` is 0 in a write address clock and 1 from the write data clock until its acknowledge.
- R8: Size code 0 selects one byte lane, code 1 selects two lanes aligned on address bit 1, and codes 2 and 3 select all four lanes. The lane index is taken from the low two address bits. Lane 0 is `bus_data_o[31:24]`, and lane 3 is `bus_data_o[7:0]`. Selected lanes carry the request write data in the same bit positions, and unselected lanes are driven 0.
- R9: `bus_lock_last_o` is 1 only in the address clock of the final write beat.
- R10: `bus_lock_o` rises with the first read start and falls in the clock after the final write acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, can take a request |
| req_addr_i | input | 32 | Operand byte address |
| req_size_i | input | 2 | 0 byte, 1 word, 2 long, 3 line (handled as long) |
| req_wdata_i | input | 32 | Word written in every write beat |
| req_rd_beats_i | input | 2 | Read beats minus one |
| req_wr_beats_i | input | 2 | Write beats minus one |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 32 | Acknowledged read word |
| bus_addr_o | output | 32 | Bus address |
| bus_size_o | output | 2 | Transfer size attribute |
| bus_rnw_o | output | 1 | 1 read, 0 write |
| bus_start_o | output | 1 | Transfer start strobe |
| bus_busy_o | output | 1 | Transfer in progress |
| bus_lock_o | output | 1 | Locked operation active |
| bus_lock_last_o | output | 1 | Address clock of the final locked write |
| bus_data_o | output | 32 | Write data |
| bus_data_oe_o | output | 1 | Write data drive enable |
| bus_data_i | input | 32 | Read data |
| bus_ack_i | input | 1 | Transfer acknowledge |

## Verification
The vector table covers four groups of patterns:
- Single-beat operations with no wait states, which show the minimum two-clock beat and the turnaround.
- Several read and write beats, which show the address step, the beat counting and that the lock-last strobe sits only on the final write beat.
- Acknowledges delayed by up to three clocks, during which the bus is fed changing non-acknowledged data. These show that only the acknowledged word reaches the client and that control and write data are held during the wait.
- Byte, word and long sizes at each lane offset, which show the lane selection and big-endian placement.

A directed run then applies reset in the middle of a write phase.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ADR,
    ST_RD_DAT,
    ST_GAP,
    ST_WR_ADR,
    ST_WR_DAT
  } seq_st_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
endpackage

// File: rtl/rmw_lane_sel.sv
module rmw_lane_sel #(
  parameter int DATA_W = 32,
  localparam int NLANE = DATA_W / 8,
  localparam int OFF_W = $clog2(NLANE)
) (
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [NLANE-1:0]  mask_o,
  output logic [DATA_W-1:0] data_o
);
  import rmw_pkg::*;

  int span;
  int base;

  always_comb begin
    case (size_i)
      SZ_BYTE: span = 1;
      SZ_WORD: span = 2;
      default: span = NLANE;
    endcase
    base = int'(off_i) & ~(span - 1);
  end

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    assign mask_o[i] = (i >= base) && (i < base + span);
    // lane 0 is the most significant byte
    assign data_o[DATA_W-1-8*i -: 8] = mask_o[i] ? data_i[DATA_W-1-8*i -: 8] : 8'h00;
  end
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl #(
  parameter int BEAT_W    = 2,
  parameter int IDLE_CLKS = 1,
  localparam int GAP_W    = (IDLE_CLKS > 1) ? $clog2(IDLE_CLKS) : 1,
  localparam int GAP_LAST = (IDLE_CLKS > 0) ? IDLE_CLKS - 1 : 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [BEAT_W-1:0] rd_last_i,
  input  logic [BEAT_W-1:0] wr_last_i,
  input  logic              ack_i,
  output rmw_pkg::seq_st_e  st_o,
  output logic [BEAT_W-1:0] beat_o
);
  import rmw_pkg::*;

  seq_st_e           st_q, st_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [GAP_W-1:0]  gap_q, gap_d;

  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    gap_d  = gap_q;
    case (st_q)
      ST_IDLE: if (go_i) begin
        st_d   = ST_RD_ADR;
        beat_d = '0;
      end
      ST_RD_ADR: st_d = ST_RD_DAT;
      ST_RD_DAT: if (ack_i) begin
        if (beat_q == rd_last_i) begin
          beat_d = '0;
          gap_d  = '0;
          st_d   = (IDLE_CLKS > 0) ? ST_GAP : ST_WR_ADR;
        end else begin
          beat_d = beat_q + 1'b1;
          st_d   = ST_RD_ADR;
        end
      end
      ST_GAP: begin
        if (gap_q == GAP_W'(GAP_LAST)) st_d = ST_WR_ADR;
        else                           gap_d = gap_q + 1'b1;
      end
      ST_WR_ADR: st_d = ST_WR_DAT;
      ST_WR_DAT: if (ack_i) begin
        if (beat_q == wr_last_i) begin
          st_d   = ST_IDLE;
          beat_d = '0;
        end else begin
          beat_d = beat_q + 1'b1;
          st_d   = ST_WR_ADR;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      gap_q  <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      gap_q  <= gap_d;
    end
  end

  assign st_o   = st_q;
  assign beat_o = beat_q;

  assert_gap_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_GAP) |-> (gap_q <= GAP_W'(GAP_LAST)));
endmodule

// File: rtl/rmw_bus_seq.sv
module rmw_bus_seq #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BEAT_W    = 2,
  parameter int IDLE_CLKS = 1,
  localparam int NLANE    = DATA_W / 8,
  localparam int OFF_W    = $clog2(NLANE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [BEAT_W-1:0] req_rd_beats_i,
  input  logic [BEAT_W-1:0] req_wr_beats_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_size_o,
  output logic              bus_rnw_o,
  output logic              bus_start_o,
  output logic              bus_busy_o,
  output logic              bus_lock_o,
  output logic              bus_lock_last_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe_o,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_ack_i
);
  import rmw_pkg::*;

  seq_st_e           st;
  logic [BEAT_W-1:0] beat;
  logic              go;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BEAT_W-1:0] rd_last_q, wr_last_q;
  logic [NLANE-1:0]  lane_mask;
  logic [DATA_W-1:0] wdata_lanes;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  assign req_ready_o = (st == ST_IDLE);
  assign go          = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      size_q    <= '0;
      wdata_q   <= '0;
      rd_last_q <= '0;
      wr_last_q <= '0;
    end else if (go) begin
      addr_q    <= req_addr_i;
      size_q    <= req_size_i;
      wdata_q   <= req_wdata_i;
      rd_last_q <= req_rd_beats_i;
      wr_last_q <= req_wr_beats_i;
    end
  end

  rmw_ctrl #(
    .BEAT_W   (BEAT_W),
    .IDLE_CLKS(IDLE_CLKS)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .rd_last_i(rd_last_q),
    .wr_last_i(wr_last_q),
    .ack_i    (bus_ack_i),
    .st_o     (st),
    .beat_o   (beat)
  );

  rmw_lane_sel #(
    .DATA_W(DATA_W)
  ) u_lanes (
    .size_i(size_q),
    .off_i (addr_q[OFF_W-1:0]),
    .data_i(wdata_q),
    .mask_o(lane_mask),
    .data_o(wdata_lanes)
  );

  // every sampling edge captures; only an acknowledged capture is flagged valid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= (st == ST_RD_DAT) && bus_ack_i;
      if (st == ST_RD_DAT) rd_data_q <= bus_data_i;
    end
  end

  assign rd_valid_o      = rd_valid_q;
  assign rd_data_o       = rd_data_q;
  assign bus_addr_o      = (st == ST_IDLE) ? '0 : addr_q + (ADDR_W'(beat) << 2);
  assign bus_size_o      = size_q;
  assign bus_start_o     = (st == ST_RD_ADR) || (st == ST_WR_ADR);
  assign bus_busy_o      = (st != ST_IDLE) && (st != ST_GAP);
  assign bus_rnw_o       = !((st == ST_WR_ADR) || (st == ST_WR_DAT));
  assign bus_lock_o      = (st != ST_IDLE);
  assign bus_lock_last_o = (st == ST_WR_ADR) && (beat == wr_last_q);
  assign bus_data_oe_o   = (st == ST_WR_DAT);
  assign bus_data_o      = bus_data_oe_o ? wdata_lanes : '0;

  assert_start_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_start_o |=> !bus_start_o);
  assert_wait_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_busy_o && !bus_start_o && !bus_ack_i) |=>
      (bus_busy_o && !bus_start_o && $stable(bus_addr_o) && $stable(bus_data_o)));
  assert_rd_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(bus_ack_i && bus_busy_o && bus_rnw_o && !bus_start_o));
  assert_gap_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_lock_o && !bus_busy_o) |-> (bus_rnw_o && !bus_start_o && !bus_data_oe_o));
  assert_oe_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_data_oe_o |-> (!bus_rnw_o && !bus_start_o && bus_busy_o));
  assert_lanes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_data_oe_o |-> (lane_mask != '0));
  assert_lock_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_lock_last_o |-> (bus_start_o && !bus_rnw_o && bus_lock_o));
  assert_lock_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_lock_o) |-> $past(bus_ack_i && bus_data_oe_o));
endmodule

// File: tb/rmw_bus_seq_tb.sv
module rmw_bus_seq_tb;
  localparam int GAP = 2;

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [1:0]  rdb;
    logic [1:0]  wrb;
    logic [1:0]  wt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 2'd2, 32'h1122_3344, 2'd0, 2'd0, 2'd0},
    '{32'h0000_2001, 2'd0, 32'hA1B2_C3D4, 2'd0, 2'd0, 2'd1},
    '{32'h0000_3002, 2'd0, 32'h5566_7788, 2'd1, 2'd0, 2'd0},
    '{32'h0000_4003, 2'd0, 32'h99AA_BBCC, 2'd0, 2'd2, 2'd2},
    '{32'h0000_5000, 2'd1, 32'hDEAD_BEEF, 2'd2, 2'd1, 2'd1},
    '{32'h0000_6002, 2'd1, 32'hCAFE_F00D, 2'd0, 2'd0, 2'd3},
    '{32'h0000_7001, 2'd3, 32'h0F1E_2D3C, 2'd3, 2'd3, 2'd0},
    '{32'h0000_8000, 2'd0, 32'h7766_5544, 2'd1, 2'd1, 2'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_rdb = '0;
  logic [1:0]  req_wrb = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic        bus_rnw, bus_start, bus_busy, bus_lock, bus_lock_last, bus_oe;
  logic [31:0] bus_dout;
  logic [31:0] bus_din = '0;
  logic        bus_ack = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  rmw_bus_seq #(.IDLE_CLKS(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .req_rd_beats_i(req_rdb), .req_wr_beats_i(req_wrb),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .bus_addr_o(bus_addr), .bus_size_o(bus_size), .bus_rnw_o(bus_rnw),
    .bus_start_o(bus_start), .bus_busy_o(bus_busy), .bus_lock_o(bus_lock),
    .bus_lock_last_o(bus_lock_last), .bus_data_o(bus_dout),
    .bus_data_oe_o(bus_oe), .bus_data_i(bus_din), .bus_ack_i(bus_ack)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // R8 lane model: lane 0 = bits 31:24
  function automatic logic [31:0] lane_data(input logic [1:0] sz, input logic [1:0] off,
                                            input logic [31:0] d);
    logic [3:0]  m;
    logic [31:0] r;
    case (sz)
      2'd0:    m = 4'b0001 << off;
      2'd1:    m = off[1] ? 4'b1100 : 4'b0011;
      default: m = 4'b1111;
    endcase
    r = '0;
    for (int i = 0; i < 4; i++) if (m[i]) r[31-8*i -: 8] = d[31-8*i -: 8];
    return r;
  endfunction

  task automatic idle_checks(input string tag);
    check({tag, " R1 ready"}, req_ready, 1);
    check({tag, " R1 lock"}, bus_lock, 0);
    check({tag, " R1 busy"}, bus_busy, 0);
    check({tag, " R1 start"}, bus_start, 0);
    check({tag, " R1 oe"}, bus_oe, 0);
    check({tag, " R1 lock_last"}, bus_lock_last, 0);
  endtask

  task automatic run(input vec_t v);
    logic [31:0] wexp;
    logic [31:0] word;
    wexp = lane_data(v.size, v.addr[1:0], v.wdata);
    @(negedge clk);
    req_valid = 1'b1; req_addr = v.addr; req_size = v.size; req_wdata = v.wdata;
    req_rdb = v.rdb; req_wrb = v.wrb;
    check("R1 ready before request", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int b = 0; b <= int'(v.rdb); b++) begin
      word = v.wdata ^ (32'h5A00_00A5 + 32'(b));
      check("R2 rd start", bus_start, 1);
      check("R2 rd busy", bus_busy, 1);
      check("R2 rd addr", bus_addr, v.addr + 32'(4 * b));
      check("R2 rd size", 32'(bus_size), 32'(v.size));
      check("R7 rd rnw", bus_rnw, 1);
      check("R10 lock in read", bus_lock, 1);
      check("R1 ready low when busy", req_ready, 0);
      check("R9 no lock_last in read", bus_lock_last, 0);
      @(negedge clk);
      check("R2 start negated", bus_start, 0);
      check("R2 rd data busy", bus_busy, 1);
      for (int w = 0; w <= int'(v.wt); w++) begin
        bus_ack = (w == int'(v.wt));
        bus_din = bus_ack ? word : (32'hBAD0_0000 | 32'(w));
        @(negedge clk);
        if (w < int'(v.wt)) begin
          check("R3 rd wait busy", bus_busy, 1);
          check("R3 rd wait start", bus_start, 0);
          check("R4 no pulse without ack", rd_valid, 0);
        end
      end
      bus_ack = 1'b0;
      check("R4 rd_valid", rd_valid, 1);
      check("R4 rd_data", rd_data, word);
    end
    for (int g = 0; g < GAP; g++) begin
      check("R6 gap busy", bus_busy, 0);
      check("R6 gap start", bus_start, 0);
      check("R6 gap rnw", bus_rnw, 1);
      check("R6 gap oe", bus_oe, 0);
      check("R6 gap lock", bus_lock, 1);
      @(negedge clk);
    end
    for (int b = 0; b <= int'(v.wrb); b++) begin
      check("R2 wr start", bus_start, 1);
      check("R2 wr addr", bus_addr, v.addr + 32'(4 * b));
      check("R7 wr rnw", bus_rnw, 0);
      check("R7 no oe in wr address clock", bus_oe, 0);
      check("R9 lock_last", bus_lock_last, (b == int'(v.wrb)) ? 1 : 0);
      check("R10 lock in write", bus_lock, 1);
      @(negedge clk);
      check("R7 oe", bus_oe, 1);
      check("R7 wr data rnw", bus_rnw, 0);
      check("R8 write lanes", bus_dout, wexp);
      for (int w = 0; w <= int'(v.wt); w++) begin
        bus_ack = (w == int'(v.wt));
        @(negedge clk);
        if (w < int'(v.wt)) begin
          check("R3 wr wait oe", bus_oe, 1);
          check("R3 wr wait data", bus_dout, wexp);
          check("R3 wr wait start", bus_start, 0);
        end
      end
      bus_ack = 1'b0;
    end
    check("R10 lock released", bus_lock, 0);
    check("R10 busy released", bus_busy, 0);
    check("R5 back to ready", req_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_checks("reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_checks("post reset");
    for (int i = 0; i < NV; i++) run(VECS[i]);
    // R8: a byte write at every lane offset
    for (int o = 0; o < 4; o++)
      run('{32'h0000_9000 + 32'(o), 2'd0, 32'h8192_A3B4, 2'd0, 2'd0, 2'd0});
    // R1: asynchronous reset in the middle of a write data wait
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_A000; req_size = 2'd2; req_rdb = '0; req_wrb = 2'd1;
    @(negedge clk);
    req_valid = 1'b0;
    bus_ack = 1'b1;
    repeat (2) @(negedge clk);
    bus_ack = 1'b0;
    repeat (GAP + 2) @(negedge clk);
    check("R1 mid-write oe before reset", bus_oe, 1);
    rst_n = 1'b0;
    #1;
    idle_checks("async reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_checks("after async reset");
    run(VECS[0]);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule